// File: doc/BRIEF.md
# Idle and Power-Down Clock Controller

This block owns the power control register of a small controller core and turns its contents into clock enables. Software writes the register to halt only the processor clock (idle), or to stop the oscillator and every internal clock (power-down). Enabled interrupt requests, or a long enough pulse on the reset pin, bring the core back to normal operation. The block also drives the forced levels of the external address-latch and program-store strobes while the core sleeps.

Leaving power-down through an enabled external interrupt first restarts the oscillator. The internal clocks then stay gated for a fixed settling window, which an internal counter measures. A qualified reset skips that window. Leaving idle through any enabled interrupt clears the idle bit in hardware. The free-running `clk` input models the oscillator so that the block can be simulated; `osc_run_o` reports whether a real oscillator would be running.

Top module: `lp_clkgate_ctrl`

## Requirements
- R1: After `rst_n` is released, the register reads 0x00, `cpu_clk_en_o`, `per_clk_en_o` and `osc_run_o` are 1, and `strobe_force_o` and `wake_o` are 0.
- R2: Register bit 0 is the idle request, bit 1 is the power-down request and bits 3:2 are two general-purpose flags. The flags read back as written and bits 7:4 always read 0.
- R3: A write with bit 0 set and bit 1 clear sets the idle bit. From the next cycle `cpu_clk_en_o` is 0, `per_clk_en_o` and `osc_run_o` stay 1, and `strobe_force_o`=1 with `strobe_level_o`=1.
- R4: A write with bit 1 set sets the power-down bit. From the next cycle `osc_run_o`, `per_clk_en_o` and `cpu_clk_en_o` are 0, and `strobe_force_o`=1 with `strobe_level_o`=0.
- R5: When bits 0 and 1 are written as 1 together, power-down is entered and the idle bit reads 0.
- R6: In idle, an external request whose enable is set, or `any_irq_i`, clears the idle bit and sets `cpu_clk_en_o` at the next edge. `wake_o` is then 1 for exactly one cycle. A request whose enable is clear has no effect.
- R7: In power-down, an enabled external request sets `osc_run_o` at the next edge. The clock enables then stay 0 for `SETTLE_CYC` (1536) cycles counted from that edge, and then both return to 1. At that same edge the power-down bit clears, and `wake_o` pulses once on the following cycle. A request whose enable is clear has no effect.
- R8: When `rst_pin_i` is sampled high on `RST_HOLD` (24) consecutive edges, the register clears to 0x00 and all enables return to 1 at the last of those edges, with no settling delay. A high run one edge shorter changes nothing.
- R9: The general-purpose flags keep their values across idle and power-down wake-ups.
- R10: Register writes are ignored while `cpu_clk_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running oscillator clock (model) |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| reg_wr_i | input | 1 | Register write strobe from the core |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| ext_req_i | input | NUM_WAKE | External interrupt requests usable for wake-up |
| ext_en_i | input | NUM_WAKE | Per-source enables for `ext_req_i` |
| any_irq_i | input | 1 | Any other enabled interrupt pending (idle exit only) |
| rst_pin_i | input | 1 | Reset pin, active high, qualified by hold time |
| cpu_clk_en_o | output | 1 | Processor clock enable |
| per_clk_en_o | output | 1 | Timer, serial and interrupt logic clock enable |
| osc_run_o | output | 1 | Oscillator run request |
| strobe_force_o | output | 1 | Address-latch and program-store strobes forced |
| strobe_level_o | output | 1 | Level of the strobes when forced |
| wake_o | output | 1 | One-cycle pulse when the core resumes after a wake |

## Verification
The assertions check on every cycle how the enables relate to each other and to the strobe levels. They also check that power-down wins over idle, that the reserved bits read 0, and that halted writes leave the flags alone. A checker counter holds every settling window to exactly `SETTLE_CYC` cycles, and another confirms that a qualified reset pin always clears the register. Only the directed scenarios show certain things: the exact edge at which each enable returns, that a disabled source or a 23-cycle reset pulse has no effect, that `wake_o` pulses after an interrupt wake but not after a reset, and that the flags survive complete sleep and wake sequences.

// File: rtl/lp_clkgate_pkg.sv
package lp_clkgate_pkg;

  // Register bit positions, decoded by software
  localparam int unsigned BIT_IDL = 0;
  localparam int unsigned BIT_PD  = 1;
  localparam int unsigned BIT_GF0 = 2;
  localparam int unsigned BIT_GF1 = 3;
  localparam int unsigned REG_W   = 8;

  typedef enum logic [1:0] {
    MODE_RUN    = 2'd0,
    MODE_IDLE   = 2'd1,
    MODE_DOWN   = 2'd2,
    MODE_SETTLE = 2'd3
  } lp_mode_e;

  typedef struct packed {
    logic [1:0] gf;
    logic       pd;
    logic       idl;
  } pcr_t;

endpackage

// File: rtl/lp_rst_filter.sv
module lp_rst_filter #(
  parameter int unsigned HOLD = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic clear_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);
  localparam logic [CW-1:0] TOP  = CW'(HOLD);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (!pin_i)          cnt_d = '0;
    else if (cnt_q != TOP) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // Takes effect at the edge that completes the HOLD-th high sample
  assign clear_o = pin_i && (cnt_q >= LAST);

endmodule

// File: rtl/lp_pcr_reg.sv
module lp_pcr_reg
  import lp_clkgate_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             wr_ok_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic             idl_clr_i,
  input  logic             pd_clr_i,
  output pcr_t             pcr_o,
  output logic [REG_W-1:0] rdata_o
);
  pcr_t pcr_q, pcr_d;

  always_comb begin
    pcr_d = pcr_q;
    if (clear_i) begin
      pcr_d = '0;
    end else if (wr_ok_i) begin
      pcr_d.gf  = {wdata_i[BIT_GF1], wdata_i[BIT_GF0]};
      pcr_d.pd  = wdata_i[BIT_PD];
      pcr_d.idl = wdata_i[BIT_IDL] & ~wdata_i[BIT_PD];
    end else begin
      if (idl_clr_i) pcr_d.idl = 1'b0;
      if (pd_clr_i)  pcr_d.pd  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcr_q <= '0;
    else        pcr_q <= pcr_d;
  end

  always_comb begin
    rdata_o          = '0;
    rdata_o[BIT_IDL] = pcr_q.idl;
    rdata_o[BIT_PD]  = pcr_q.pd;
    rdata_o[BIT_GF0] = pcr_q.gf[0];
    rdata_o[BIT_GF1] = pcr_q.gf[1];
  end

  assign pcr_o = pcr_q;

endmodule

// File: rtl/lp_mode_fsm.sv
module lp_mode_fsm
  import lp_clkgate_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 1536
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     clear_i,
  input  logic     go_idle_i,
  input  logic     go_down_i,
  input  logic     ext_wake_i,
  input  logic     any_irq_i,
  output lp_mode_e mode_o,
  output logic     idle_exit_o,
  output logic     settle_done_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  lp_mode_e      mode_q, mode_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    mode_d        = mode_q;
    cnt_d         = cnt_q;
    idle_exit_o   = 1'b0;
    settle_done_o = 1'b0;
    if (clear_i) begin
      mode_d = MODE_RUN;
      cnt_d  = '0;
    end else begin
      unique case (mode_q)
        MODE_RUN: begin
          if (go_down_i)      mode_d = MODE_DOWN;
          else if (go_idle_i) mode_d = MODE_IDLE;
        end
        MODE_IDLE: begin
          if (ext_wake_i || any_irq_i) begin
            mode_d      = MODE_RUN;
            idle_exit_o = 1'b1;
          end
        end
        MODE_DOWN: begin
          if (ext_wake_i) begin
            mode_d = MODE_SETTLE;
            cnt_d  = '0;
          end
        end
        MODE_SETTLE: begin
          if (cnt_q == LAST) begin
            mode_d        = MODE_RUN;
            cnt_d         = '0;
            settle_done_o = 1'b1;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      cnt_q  <= '0;
    end else begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
    end
  end

  assign mode_o = mode_q;

endmodule

// File: rtl/lp_clkgate_ctrl.sv
module lp_clkgate_ctrl
  import lp_clkgate_pkg::*;
#(
  parameter int unsigned NUM_WAKE   = 8,
  parameter int unsigned SETTLE_CYC = 1536,
  parameter int unsigned RST_HOLD   = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_i,
  input  logic [7:0]          reg_wdata_i,
  output logic [7:0]          reg_rdata_o,
  input  logic [NUM_WAKE-1:0] ext_req_i,
  input  logic [NUM_WAKE-1:0] ext_en_i,
  input  logic                any_irq_i,
  input  logic                rst_pin_i,
  output logic                cpu_clk_en_o,
  output logic                per_clk_en_o,
  output logic                osc_run_o,
  output logic                strobe_force_o,
  output logic                strobe_level_o,
  output logic                wake_o
);
  logic                clear;
  logic                wr_ok;
  logic                go_idle, go_down;
  logic                ext_wake;
  logic                idle_exit, settle_done;
  logic [NUM_WAKE-1:0] armed;
  lp_mode_e            mode;
  pcr_t                pcr;
  logic                wake_q, wake_d;

  // Per-source qualification of the wake requests
  for (genvar g = 0; g < NUM_WAKE; g++) begin : g_wake_src
    assign armed[g] = ext_req_i[g] & ext_en_i[g];
  end
  assign ext_wake = |armed;

  lp_rst_filter #(.HOLD(RST_HOLD)) i_rst_filter (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_i   (rst_pin_i),
    .clear_o (clear)
  );

  assign wr_ok   = reg_wr_i && (mode == MODE_RUN) && !clear;
  assign go_down = wr_ok && reg_wdata_i[BIT_PD];
  assign go_idle = wr_ok && reg_wdata_i[BIT_IDL] && !reg_wdata_i[BIT_PD];

  lp_pcr_reg i_pcr_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (clear),
    .wr_ok_i   (wr_ok),
    .wdata_i   (reg_wdata_i),
    .idl_clr_i (idle_exit),
    .pd_clr_i  (settle_done),
    .pcr_o     (pcr),
    .rdata_o   (reg_rdata_o)
  );

  lp_mode_fsm #(.SETTLE_CYC(SETTLE_CYC)) i_mode_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .clear_i       (clear),
    .go_idle_i     (go_idle),
    .go_down_i     (go_down),
    .ext_wake_i    (ext_wake),
    .any_irq_i     (any_irq_i),
    .mode_o        (mode),
    .idle_exit_o   (idle_exit),
    .settle_done_o (settle_done)
  );

  assign wake_d = idle_exit | settle_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= wake_d;
  end

  always_comb begin
    cpu_clk_en_o   = (mode == MODE_RUN);
    per_clk_en_o   = (mode == MODE_RUN) || (mode == MODE_IDLE);
    osc_run_o      = (mode != MODE_DOWN);
    strobe_force_o = (mode != MODE_RUN);
    strobe_level_o = (mode == MODE_IDLE);
  end

  assign wake_o = wake_q;

  logic unused_pcr;
  assign unused_pcr = ^pcr;

endmodule

// File: rtl/lp_clkgate_chk.sv
module lp_clkgate_chk #(
  parameter int unsigned SETTLE_CYC = 1536,
  parameter int unsigned RST_HOLD   = 24
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       rst_pin_i,
  input logic       cpu_clk_en_o,
  input logic       per_clk_en_o,
  input logic       osc_run_o,
  input logic       strobe_force_o,
  input logic       strobe_level_o,
  input logic       wake_o
);
  localparam int unsigned SW = $clog2(SETTLE_CYC + 2);
  localparam int unsigned PW = $clog2(RST_HOLD + 1);

  logic [SW-1:0] settle_cnt;
  logic [PW-1:0] pin_cnt;
  logic          settling;

  assign settling = osc_run_o && !per_clk_en_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        settle_cnt <= '0;
    else if (settling) settle_cnt <= settle_cnt + 1'b1;
    else               settle_cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         pin_cnt <= '0;
    else if (!rst_pin_i)                pin_cnt <= '0;
    else if (pin_cnt != PW'(RST_HOLD))  pin_cnt <= pin_cnt + 1'b1;
  end

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata_o[7:4] == 4'h0);

  // R3
  cpu_needs_per_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clk_en_o |-> per_clk_en_o);

  // R3
  idle_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_clk_en_o && !cpu_clk_en_o) |-> (strobe_force_o && strobe_level_o));

  // R4
  osc_stop_gates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_run_o |-> (!per_clk_en_o && !cpu_clk_en_o && strobe_force_o && !strobe_level_o));

  // R5
  pd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && cpu_clk_en_o && reg_wdata_i[1] && !rst_pin_i)
      |=> (!osc_run_o && !reg_rdata_o[0] && reg_rdata_o[1]));

  // R6
  wake_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |-> cpu_clk_en_o);

  // R6
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_o |=> !wake_o);

  // R7
  settle_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (settle_cnt < SW'(SETTLE_CYC)));

  // R7
  settle_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en_o) && $past(settling) && !$past(rst_pin_i))
      |-> (settle_cnt == SW'(SETTLE_CYC)));

  // R8
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_pin_i && pin_cnt >= PW'(RST_HOLD - 1))
      |=> (reg_rdata_o == 8'h00 && cpu_clk_en_o && osc_run_o));

  // R9
  flags_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cpu_clk_en_o) && !$past(rst_pin_i)) |-> $stable(reg_rdata_o[3:2]));

  // R10
  halted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && !cpu_clk_en_o && !rst_pin_i) |=> $stable(reg_rdata_o[3:2]));

endmodule

bind lp_clkgate_ctrl lp_clkgate_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .RST_HOLD   (RST_HOLD)
) i_lp_clkgate_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .reg_wr_i       (reg_wr_i),
  .reg_wdata_i    (reg_wdata_i),
  .reg_rdata_o    (reg_rdata_o),
  .rst_pin_i      (rst_pin_i),
  .cpu_clk_en_o   (cpu_clk_en_o),
  .per_clk_en_o   (per_clk_en_o),
  .osc_run_o      (osc_run_o),
  .strobe_force_o (strobe_force_o),
  .strobe_level_o (strobe_level_o),
  .wake_o         (wake_o)
);

// File: tb/test_lp_clkgate_ctrl.sv
`timescale 1ns/1ps
module test_lp_clkgate_ctrl;
  localparam int NW     = 8;
  localparam int SETTLE = 1536;
  localparam int HOLD   = 24;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr_i;
  logic [7:0]    reg_wdata_i;
  logic [7:0]    reg_rdata_o;
  logic [NW-1:0] ext_req_i, ext_en_i;
  logic          any_irq_i, rst_pin_i;
  logic          cpu_clk_en_o, per_clk_en_o, osc_run_o;
  logic          strobe_force_o, strobe_level_o, wake_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lp_clkgate_ctrl #(.NUM_WAKE(NW), .SETTLE_CYC(SETTLE), .RST_HOLD(HOLD)) i_lp_clkgate_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .ext_req_i(ext_req_i), .ext_en_i(ext_en_i),
    .any_irq_i(any_irq_i), .rst_pin_i(rst_pin_i), .cpu_clk_en_o(cpu_clk_en_o),
    .per_clk_en_o(per_clk_en_o), .osc_run_o(osc_run_o),
    .strobe_force_o(strobe_force_o), .strobe_level_o(strobe_level_o), .wake_o(wake_o)
  );

  task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // status = {wake, level, force, osc, per, cpu}
  function automatic logic [7:0] st();
    return {2'b00, wake_o, strobe_level_o, strobe_force_o, osc_run_o, per_clk_en_o, cpu_clk_en_o};
  endfunction

  localparam logic [7:0] ST_RUN   = 8'b00_0_0_0_1_1_1;
  localparam logic [7:0] ST_WAKE  = 8'b00_1_0_0_1_1_1;
  localparam logic [7:0] ST_IDLE  = 8'b00_0_1_1_1_1_0;
  localparam logic [7:0] ST_DOWN  = 8'b00_0_0_1_0_0_0;
  localparam logic [7:0] ST_SETTL = 8'b00_0_0_1_1_0_0;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    reg_wr_i = 1'b1; reg_wdata_i = d;
    tick(1);
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00;
  endtask

  task automatic t_reset();
    chk("R1", "reset reg", reg_rdata_o, 8'h00);
    chk("R1", "reset status", st(), ST_RUN);
  endtask

  task automatic t_layout();
    wr(8'hFC);
    chk("R2", "flags+reserved read", reg_rdata_o, 8'h0C);
    chk("R2", "still running", st(), ST_RUN);
    wr(8'h04);
    chk("R2", "flag0 only", reg_rdata_o, 8'h04);
  endtask

  task automatic t_idle_ext();
    wr(8'h09);
    chk("R3", "idle reg", reg_rdata_o, 8'h09);
    chk("R3", "idle status", st(), ST_IDLE);
    ext_req_i = 8'h20; ext_en_i = 8'hDF;
    tick(3);
    chk("R6", "disabled src ignored", st(), ST_IDLE);
    ext_en_i = 8'h20;
    tick(1);
    ext_req_i = '0;
    chk("R6", "idle exit status", st(), ST_WAKE);
    chk("R6", "idl cleared", reg_rdata_o, 8'h08);
    chk("R9", "flags after idle", reg_rdata_o[3:2], 8'h02);
    tick(1);
    chk("R6", "wake one cycle", st(), ST_RUN);
  endtask

  task automatic t_idle_any();
    wr(8'h01);
    chk("R3", "idle again", st(), ST_IDLE);
    wr(8'h0E);
    chk("R10", "write in idle ignored", reg_rdata_o, 8'h01);
    chk("R10", "idle kept", st(), ST_IDLE);
    any_irq_i = 1'b1;
    tick(1);
    any_irq_i = 1'b0;
    chk("R6", "any irq exit", st(), ST_WAKE);
    chk("R6", "idl cleared any", reg_rdata_o, 8'h00);
  endtask

  task automatic t_pd_wake();
    wr(8'h0B);
    chk("R5", "pd over idl reg", reg_rdata_o, 8'h0A);
    chk("R4", "down status", st(), ST_DOWN);
    ext_req_i = 8'h01; ext_en_i = 8'hFE;
    tick(4);
    chk("R7", "disabled src in pd", st(), ST_DOWN);
    ext_en_i = 8'h08; ext_req_i = 8'h08;
    tick(1);
    ext_req_i = '0;
    chk("R7", "osc restarted", st(), ST_SETTL);
    wr(8'h04);
    chk("R10", "settle write ignored", reg_rdata_o, 8'h0A);
    tick(SETTLE - 2);
    chk("R7", "last gated cycle", st(), ST_SETTL);
    tick(1);
    chk("R7", "resume status", st(), ST_WAKE);
    chk("R7", "pd cleared", reg_rdata_o, 8'h08);
    chk("R9", "flags after pd", reg_rdata_o[3:2], 8'h02);
    tick(1);
    chk("R7", "wake pulse ends", st(), ST_RUN);
  endtask

  task automatic t_rst_pin();
    wr(8'h06);
    chk("R4", "pd for reset test", st(), ST_DOWN);
    rst_pin_i = 1'b1;
    tick(HOLD - 1);
    rst_pin_i = 1'b0;
    chk("R8", "short pulse status", st(), ST_DOWN);
    chk("R8", "short pulse reg", reg_rdata_o, 8'h06);
    tick(2);
    rst_pin_i = 1'b1;
    tick(HOLD - 1);
    chk("R8", "before last edge", st(), ST_DOWN);
    tick(1);
    chk("R8", "reset wake no delay", st(), ST_RUN);
    chk("R8", "reset clears reg", reg_rdata_o, 8'h00);
    wr(8'h0C);
    chk("R8", "write during reset ignored", reg_rdata_o, 8'h00);
    rst_pin_i = 1'b0;
    tick(1);
    wr(8'h0D);
    chk("R3", "idle after reset", st(), ST_IDLE);
    rst_pin_i = 1'b1;
    tick(HOLD);
    rst_pin_i = 1'b0;
    chk("R8", "reset exits idle", st(), ST_RUN);
    chk("R8", "idle reset reg", reg_rdata_o, 8'h00);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    ext_req_i = '0; ext_en_i = '0; any_irq_i = 1'b0; rst_pin_i = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_layout();
    t_idle_ext();
    t_idle_any();
    t_pd_wake();
    t_rst_pin();
    tick(2);
    finish_run();
  end
endmodule